// File: doc/BRIEF.md
# Fractional M/N Clock-Enable Divider

This block produces a one-cycle clock-enable pulse on its `tick` output at an average rate of M/N of the reference clock. Each enabled cycle a phase accumulator adds M. When the sum reaches N or passes it, N is taken off and a tick is issued. Downstream logic that runs on the reference clock qualifies its registers with `tick` to obtain the divided rate. With M equal to N every enabled cycle ticks, so the divider passes the reference rate straight through.

Software programs the divider through a single 32-bit control word. The word carries a 15-bit denominator, a 15-bit numerator, an output-enable bit and a self-clearing update request. The numerator and denominator land in shadow registers first. They reach the running accumulator only when an update is requested, so a ratio that is only partly written never drives the output. A requested ratio is checked when it is transferred. A ratio that cannot be produced (numerator above denominator, or a zero denominator) is refused: the running ratio stays as it was and an error flag is raised.

Top module: `frac_clk_div`

## Requirements
- R1: The control word is laid out as follows: bits [30:16] are N, bits [15:1] are M, bit 0 is the output enable and bit 31 is the update request. A write takes effect on the clock edge where `wr_en` is high. `rd_data` returns the shadow N, the shadow M and the enable in the same positions, with bit 31 showing a pending update.
- R2: While the enable bit is zero, `tick` is low from the cycle after the enable is sampled low.
- R3: A write with bit 31 set makes the pending bit read 1 for exactly one cycle. The bit then clears itself at the edge that performs the transfer, unless another update is written at that edge.
- R4: Starting from a cleared accumulator, exactly floor(j*M/N) ticks appear over j enabled accumulation cycles. The accumulator always stays below the active N.
- R5: When the active M equals the active N, `tick` is high on every enabled cycle, so the reference rate passes through.
- R6: If the shadow ratio has M > N or N = 0 when an update is transferred, the active ratio keeps its previous value and `err` goes to 1. A valid transfer clears `err` to 0.
- R7: A write without bit 31 changes only the shadow values. The rate produced at `tick` keeps following the previously active ratio.
- R8: After reset, `rd_data` reads 0x0001_0002 (M = 1, N = 1, disabled, nothing pending), the active ratio is 1/1, and `tick` and `err` are 0.
- R9: An accepted transfer clears the accumulator and holds `tick` low in the transfer cycle. Accumulation restarts on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Shadow values, enable and pending update |
| tick | output | 1 | Registered clock-enable pulse |
| err | output | 1 | Last transferred ratio was refused |

## Verification
A write sampled at edge k shows in `rd_data` (and in the pending bit) right after k. The transfer happens at edge k+1, so `err` and the cleared, low `tick` are due after k+1. The first accumulation result appears on `tick` after k+2, and the enable bit gates `tick` from the edge after it is sampled. The bench drives inputs and samples outputs on falling edges. It reads the pending bit one falling edge after the write and reads `err` and the transfer-cycle `tick` one edge later. It then counts ticks over exactly 60 following cycles and compares the count with floor(60*M/N).

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  localparam int unsigned DEF_RATIO_W = 15;

  // outcome of a pending ratio transfer
  typedef enum logic [1:0] {
    XFER_NONE   = 2'd0,
    XFER_ACCEPT = 2'd1,
    XFER_REFUSE = 2'd2
  } xfer_t;

  function automatic logic ratio_ok(input logic [DEF_RATIO_W-1:0] m,
                                    input logic [DEF_RATIO_W-1:0] n);
    return (n != '0) && (m <= n);
  endfunction

endpackage

// File: rtl/div_cfg_reg.sv
module div_cfg_reg #(
  parameter int unsigned RATIO_W = frac_div_pkg::DEF_RATIO_W,
  localparam int unsigned REG_W  = 2*RATIO_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [RATIO_W-1:0] sh_m,
  output logic [RATIO_W-1:0] sh_n,
  output logic               out_en,
  output logic               pend
);

  localparam int unsigned UPD_BIT = REG_W - 1;
  localparam int unsigned N_LO    = RATIO_W + 1;
  localparam int unsigned N_HI    = 2*RATIO_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_m   <= RATIO_W'(1);
      sh_n   <= RATIO_W'(1);
      out_en <= 1'b0;
      pend   <= 1'b0;
    end else if (wr_en) begin
      sh_n   <= wr_data[N_HI:N_LO];
      sh_m   <= wr_data[RATIO_W:1];
      out_en <= wr_data[0];
      pend   <= wr_data[UPD_BIT];
    end else begin
      pend   <= 1'b0;
    end
  end

  // R3: a pending request lives one cycle unless re-requested
  p_pend_selfclear_r3: assert property (@(posedge clk) disable iff (rst)
    (pend && !(wr_en && wr_data[UPD_BIT])) |=> !pend);

  // R7: shadow values only move on a write
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(sh_m) && $stable(sh_n)));

endmodule

// File: rtl/div_ratio_latch.sv
module div_ratio_latch
  import frac_div_pkg::*;
#(
  parameter int unsigned RATIO_W = DEF_RATIO_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pend,
  input  logic [RATIO_W-1:0] sh_m,
  input  logic [RATIO_W-1:0] sh_n,
  output logic [RATIO_W-1:0] act_m,
  output logic [RATIO_W-1:0] act_n,
  output logic               restart,
  output logic               err
);

  xfer_t xfer;
  logic  good;

  always_comb begin
    good = (sh_n != '0) && (sh_m <= sh_n);
    if (!pend)      xfer = XFER_NONE;
    else if (good)  xfer = XFER_ACCEPT;
    else            xfer = XFER_REFUSE;
  end

  assign restart = (xfer == XFER_ACCEPT);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_m <= RATIO_W'(1);
      act_n <= RATIO_W'(1);
      err   <= 1'b0;
    end else begin
      case (xfer)
        XFER_ACCEPT: begin
          act_m <= sh_m;
          act_n <= sh_n;
          err   <= 1'b0;
        end
        XFER_REFUSE: err <= 1'b1;
        default: ;
      endcase
    end
  end

  // R6: a refused request leaves the ratio alone and flags it
  p_refuse_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (pend && ((sh_n == '0) || (sh_m > sh_n))) |=>
      ($stable(act_m) && $stable(act_n) && err));

  // R6: the active ratio is always producible
  p_active_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (act_n != '0) && (act_m <= act_n));

endmodule

// File: rtl/div_phase_acc.sv
module div_phase_acc #(
  parameter int unsigned RATIO_W = frac_div_pkg::DEF_RATIO_W,
  localparam int unsigned ACC_W  = RATIO_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               out_en,
  input  logic               restart,
  input  logic [RATIO_W-1:0] act_m,
  input  logic [RATIO_W-1:0] act_n,
  output logic               tick
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;
  logic             wrap;

  always_comb begin
    sum  = acc + {1'b0, act_m};
    wrap = (sum >= {1'b0, act_n});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (restart) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (out_en) begin
      acc  <= wrap ? (sum - {1'b0, act_n}) : sum;
      tick <= wrap;
    end else begin
      tick <= 1'b0;
    end
  end

  // R4: phase never reaches the denominator
  p_acc_bound_r4: assert property (@(posedge clk) disable iff (rst)
    acc < {1'b0, act_n});

  // R2: disabled output stays silent
  p_tick_off_r2: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !tick);

  // R5: equal ratio ticks every enabled cycle
  p_passthru_r5: assert property (@(posedge clk) disable iff (rst)
    (out_en && !restart && (act_m == act_n)) |=> tick);

  // R9: transfer cycle clears phase and output
  p_restart_clear_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!tick && (acc == '0)));

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int unsigned RATIO_W = frac_div_pkg::DEF_RATIO_W,
  localparam int unsigned REG_W  = 2*RATIO_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             tick,
  output logic             err
);

  logic [RATIO_W-1:0] sh_m, sh_n, act_m, act_n;
  logic               out_en, pend, restart;

  div_cfg_reg #(.RATIO_W(RATIO_W)) i_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sh_m    (sh_m),
    .sh_n    (sh_n),
    .out_en  (out_en),
    .pend    (pend)
  );

  div_ratio_latch #(.RATIO_W(RATIO_W)) i_latch (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend),
    .sh_m    (sh_m),
    .sh_n    (sh_n),
    .act_m   (act_m),
    .act_n   (act_n),
    .restart (restart),
    .err     (err)
  );

  div_phase_acc #(.RATIO_W(RATIO_W)) i_acc (
    .clk     (clk),
    .rst     (rst),
    .out_en  (out_en),
    .restart (restart),
    .act_m   (act_m),
    .act_n   (act_n),
    .tick    (tick)
  );

  assign rd_data = {pend, sh_n, sh_m, out_en};

  // R3: a pending bit is always caused by a write
  p_pend_from_write_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[REG_W-1]) |-> $past(wr_en));

endmodule

// File: tb/test_frac_clk_div.sv
module test_frac_clk_div;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        tick;
  logic        err;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2 clk = ~clk;   // 250 MHz

  frac_clk_div i_frac_clk_div (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .err(err)
  );

  // {M, N, expected ticks in 60 cycles}
  localparam int NVEC = 8;
  localparam logic [44:0] VEC [0:NVEC-1] = '{
    {15'd1,  15'd1,  15'd60},
    {15'd5,  15'd5,  15'd60},
    {15'd3,  15'd7,  15'd25},
    {15'd2,  15'd3,  15'd40},
    {15'd1,  15'd60, 15'd1},
    {15'd7,  15'd16, 15'd26},
    {15'd0,  15'd9,  15'd0},
    {15'd1,  15'd2,  15'd30}
  };

  function automatic logic [31:0] mk(input logic upd, input logic [14:0] n,
                                     input logic [14:0] m, input logic en);
    return {upd, n, m, en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // returns at the falling edge after the write edge
  task automatic write_reg(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic count_ticks(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cnt;
    logic [14:0] vm, vn, ve;
    rst = 1'b1; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R8 tick in reset", {31'd0, tick}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset readback", rd_data, 32'h0001_0002);
    chk("R8 reset err", {31'd0, err}, 32'd0);
    chk("R8 reset tick", {31'd0, tick}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      {vm, vn, ve} = VEC[v];
      write_reg(mk(1'b1, vn, vm, 1'b1));
      chk("R3 pending set", {31'd0, rd_data[31]}, 32'd1);
      @(negedge clk);
      chk("R3 pending cleared", {31'd0, rd_data[31]}, 32'd0);
      chk("R9 tick low at transfer", {31'd0, tick}, 32'd0);
      count_ticks(60, cnt);
      if (vm == vn) chk("R5 pass-through count", cnt, 32'(ve));
      else          chk("R4 ratio count", cnt, 32'(ve));
    end

    // active is 1/2: shadow-only write must not change the rate
    write_reg(mk(1'b0, 15'd1, 15'd1, 1'b1));
    chk("R1 readback shadow", rd_data, mk(1'b0, 15'd1, 15'd1, 1'b1));
    chk("R7 no pending", {31'd0, rd_data[31]}, 32'd0);
    count_ticks(60, cnt);
    chk("R7 rate unchanged", cnt, 32'd30);

    // refused: M > N
    write_reg(mk(1'b1, 15'd3, 15'd5, 1'b1));
    @(negedge clk);
    chk("R6 err on M>N", {31'd0, err}, 32'd1);
    count_ticks(60, cnt);
    chk("R6 ratio kept after M>N", cnt, 32'd30);

    // accepted clears err
    write_reg(mk(1'b1, 15'd2, 15'd1, 1'b1));
    @(negedge clk);
    chk("R6 err cleared", {31'd0, err}, 32'd0);

    // refused: N = 0
    write_reg(mk(1'b1, 15'd0, 15'd1, 1'b1));
    @(negedge clk);
    chk("R6 err on N=0", {31'd0, err}, 32'd1);
    count_ticks(60, cnt);
    chk("R6 ratio kept after N=0", cnt, 32'd30);

    // field placement
    write_reg(mk(1'b0, 15'd300, 15'd123, 1'b1));
    chk("R1 field readback", rd_data, 32'h012C_00F7);

    // disable
    write_reg(mk(1'b0, 15'd2, 15'd1, 1'b0));
    chk("R1 enable readback", {31'd0, rd_data[0]}, 32'd0);
    @(negedge clk);
    count_ticks(20, cnt);
    chk("R2 no ticks when disabled", cnt, 32'd0);

    // re-enable as pass-through
    write_reg(mk(1'b1, 15'd1, 15'd1, 1'b1));
    @(negedge clk);
    count_ticks(40, cnt);
    chk("R5 pass-through after re-enable", cnt, 32'd40);

    finish_run();
  end

endmodule